// File: doc/BRIEF.md
# Paged Translation Entry Permission Checker

This block takes one translation entry that a lookup has already selected and decides what a memory access may do with it. The entry holds two page descriptors, one for an even page and one for an odd page of an aligned pair. The block picks the descriptor that covers the virtual address and checks it against the access kind and the current privilege level. It then returns either a fault code or a physical address with read, write and execute permission flags.

The page size comes from one of two places: the entry carries its own size, and the fixed-size section of the translation store shares one global size. A per-request flag says which of the two applies. A mode input selects the wide-address form, in which the inhibit and restricted-privilege bits take part. In the narrow form those bits count as zero. The result is registered and appears one clock after a request strobe. The lookup and the entry storage are outside this block.

Top module: `tlb_perm_check`

## Requirements
- R1: The effective page size is `entry_ps` when `from_var_section` is 1 and `fixed_ps` when it is 0. Both sizes are given as a bit count between 12 and VA_W-1.
- R2: Bit number PS of `vaddr` selects the descriptor. A 1 selects `desc_odd` and a 0 selects `desc_even`. All further checks use only the selected descriptor.
- R3: The result code is 0 for a hit, 1 for a descriptor that is not valid, 2 for a fetch (access 2) to an execute-inhibited page, 3 for a load (access 0) from a read-inhibited page, 4 for a privilege fault, and 5 for a store (access 1) to a page whose dirty bit is clear. When several faults apply, the lowest code from 1 to 5 is reported. Access code 3 is reserved and takes part only in the valid and privilege checks.
- R4: A privilege fault occurs in two cases. If the restricted-privilege bit is 0, it occurs when `cur_plv` is numerically greater than the descriptor level. If the restricted-privilege bit is 1, it occurs when the two levels differ.
- R5: When `wide_mode` is 0, the execute-inhibit, read-inhibit and restricted-privilege bits are treated as 0.
- R6: On a hit, `paddr` is built from two parts. Its bits at and above PS come from descriptor bits [PA_W-1:PS]. Its bits below PS come from `vaddr`. The descriptor's frame bits from 12 to PS-1 are software bits and are never used.
- R7: On a hit, `perm_rd` is 1, `perm_wr` equals the dirty bit, and `perm_ex` is the inverse of the effective execute-inhibit bit. On any fault, `paddr` and all three permission flags are 0.
- R8: Each response is registered. `rsp_valid` is 1 exactly one cycle after `req_valid` is 1. Without a request, `result`, `paddr` and the permission flags hold their values. After reset, every output is 0.
- R9: The descriptor bits are laid out as follows: bit 0 valid, bit 1 dirty, bits 3:2 page privilege level, bit 4 restricted privilege, bit 5 read-inhibit, bit 6 execute-inhibit. Bits [PA_W-1:12] hold the frame. All other bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| desc_even | input | ENT_W | Descriptor for the even page of the pair |
| desc_odd | input | ENT_W | Descriptor for the odd page of the pair |
| entry_ps | input | PS_W | Page size carried by the entry |
| fixed_ps | input | PS_W | Global page size of the fixed-size section |
| from_var_section | input | 1 | 1 when the entry came from the variable-size section |
| vaddr | input | VA_W | Virtual address of the access |
| access | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| cur_plv | input | 2 | Current privilege level, 0 to 3 |
| wide_mode | input | 1 | 1 selects the wide-address form |
| rsp_valid | output | 1 | Response strobe |
| result | output | 3 | Result code |
| paddr | output | PA_W | Translated physical address |
| perm_rd | output | 1 | Read allowed |
| perm_wr | output | 1 | Write allowed |
| perm_ex | output | 1 | Execute allowed |

## Verification
Some properties are checked on every cycle. These are the response timing and the holding of outputs, that execute-inhibit faults come only from fetches and dirty faults only from stores, that narrow mode never yields an inhibit fault, and that a fault always returns a zero address and no permissions. Other behaviours can only be shown by the bench's sweep against its own arithmetic model. These are the choice of page-size source, the choice of descriptor half, the full fault priority, the privilege rule with and without restriction, and the exact address bits for each page size.

// File: rtl/tlbchk_pkg.sv
package tlbchk_pkg;
   typedef enum logic [2:0] {
      RC_HIT     = 3'd0,
      RC_NOVALID = 3'd1,
      RC_NOEXEC  = 3'd2,
      RC_NOREAD  = 3'd3,
      RC_PRIV    = 3'd4,
      RC_CLEAN   = 3'd5
   } rc_t;

   typedef enum logic [1:0] {
      AC_LOAD  = 2'd0,
      AC_STORE = 2'd1,
      AC_FETCH = 2'd2,
      AC_RSVD  = 2'd3
   } acc_t;

   // Bit positions of the descriptor fields (R9)
   localparam int FB_VALID  = 0;
   localparam int FB_DIRTY  = 1;
   localparam int FB_PLV    = 2;
   localparam int FB_RPLV   = 4;
   localparam int FB_NOREAD = 5;
   localparam int FB_NOEXEC = 6;
   localparam int FRAME_LSB = 12;

   typedef struct packed {
      logic       valid;
      logic       dirty;
      logic [1:0] plv;
      logic       rplv;
      logic       noread;
      logic       noexec;
   } flags_t;
endpackage

// File: rtl/tlbchk_half_sel.sv
module tlbchk_half_sel
   import tlbchk_pkg::*;
#(
   parameter int ENT_W     = 64,
   parameter int VA_W      = 48,
   parameter int PS_W      = 6,
   parameter bit HAS_NARROW = 1'b1
) (
   input  logic [ENT_W-1:0] desc_even,
   input  logic [ENT_W-1:0] desc_odd,
   input  logic [PS_W-1:0]  entry_ps,
   input  logic [PS_W-1:0]  fixed_ps,
   input  logic             from_var_section,
   input  logic [VA_W-1:0]  vaddr,
   input  logic             wide_mode,
   output logic [PS_W-1:0]  ps_eff,
   output logic [ENT_W-1:0] desc_sel,
   output flags_t           flags
);
   logic odd_page;
   logic ext_on;

   assign ps_eff   = from_var_section ? entry_ps : fixed_ps;
   assign odd_page = vaddr[ps_eff];
   assign desc_sel = odd_page ? desc_odd : desc_even;

   generate
      if (HAS_NARROW) begin : g_narrow
         assign ext_on = wide_mode;
      end else begin : g_wide_only
         assign ext_on = 1'b1;
      end
   endgenerate

   always_comb begin
      flags.valid  = desc_sel[FB_VALID];
      flags.dirty  = desc_sel[FB_DIRTY];
      flags.plv    = desc_sel[FB_PLV +: 2];
      flags.rplv   = desc_sel[FB_RPLV]   & ext_on;
      flags.noread = desc_sel[FB_NOREAD] & ext_on;
      flags.noexec = desc_sel[FB_NOEXEC] & ext_on;
   end
endmodule

// File: rtl/tlbchk_fault.sv
module tlbchk_fault
   import tlbchk_pkg::*;
(
   input  flags_t     flags,
   input  logic [1:0] access,
   input  logic [1:0] cur_plv,
   output rc_t        code
);
   logic priv_bad;

   always_comb begin
      if (flags.rplv) priv_bad = (cur_plv != flags.plv);
      else            priv_bad = (cur_plv > flags.plv);
   end

   always_comb begin
      if (!flags.valid)                                  code = RC_NOVALID;
      else if (access == AC_FETCH && flags.noexec)       code = RC_NOEXEC;
      else if (access == AC_LOAD && flags.noread)        code = RC_NOREAD;
      else if (priv_bad)                                 code = RC_PRIV;
      else if (access == AC_STORE && !flags.dirty)       code = RC_CLEAN;
      else                                               code = RC_HIT;
   end
endmodule

// File: rtl/tlbchk_paddr.sv
module tlbchk_paddr
   import tlbchk_pkg::*;
#(
   parameter int ENT_W = 64,
   parameter int VA_W  = 48,
   parameter int PA_W  = 48,
   parameter int PS_W  = 6
) (
   input  logic [ENT_W-1:0] desc_sel,
   input  logic [PS_W-1:0]  ps_eff,
   input  logic [VA_W-1:0]  vaddr,
   output logic [PA_W-1:0]  paddr
);
   localparam int LOW_W = FRAME_LSB;

   logic [PA_W-1:0] frame_base;
   logic [PA_W-1:0] va_ext;
   logic [PA_W-1:0] hi_mask;

   assign frame_base = {desc_sel[PA_W-1:LOW_W], {LOW_W{1'b0}}};

   generate
      if (VA_W >= PA_W) begin : g_va_trunc
         assign va_ext = vaddr[PA_W-1:0];
      end else begin : g_va_zext
         assign va_ext = {{(PA_W-VA_W){1'b0}}, vaddr};
      end
   endgenerate

   assign hi_mask = {PA_W{1'b1}} << ps_eff;
   assign paddr   = (frame_base & hi_mask) | (va_ext & ~hi_mask);
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
   import tlbchk_pkg::*;
#(
   parameter int ENT_W      = 64,
   parameter int VA_W       = 48,
   parameter int PA_W       = 48,
   parameter int PS_W       = 6,
   parameter bit HAS_NARROW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [ENT_W-1:0] desc_even,
   input  logic [ENT_W-1:0] desc_odd,
   input  logic [PS_W-1:0]  entry_ps,
   input  logic [PS_W-1:0]  fixed_ps,
   input  logic             from_var_section,
   input  logic [VA_W-1:0]  vaddr,
   input  logic [1:0]       access,
   input  logic [1:0]       cur_plv,
   input  logic             wide_mode,
   output logic             rsp_valid,
   output logic [2:0]       result,
   output logic [PA_W-1:0]  paddr,
   output logic             perm_rd,
   output logic             perm_wr,
   output logic             perm_ex
);
   localparam int MIN_PS = FRAME_LSB;

   initial begin
      assert (PA_W > MIN_PS) else $error("PA_W must exceed the 4 KiB offset width");
      assert (ENT_W >= PA_W) else $error("descriptor too narrow for the frame");
      assert ((1 << PS_W) > VA_W) else $error("PS_W cannot encode a bit index of vaddr");
      assert (ENT_W > FB_NOEXEC) else $error("descriptor too narrow for the flags");
   end

   logic [PS_W-1:0]  ps_eff;
   logic [ENT_W-1:0] desc_sel;
   flags_t           flags;
   rc_t              code;
   logic [PA_W-1:0]  pa_calc;

   tlbchk_half_sel #(
      .ENT_W(ENT_W), .VA_W(VA_W), .PS_W(PS_W), .HAS_NARROW(HAS_NARROW)
   ) u_half (
      .desc_even        (desc_even),
      .desc_odd         (desc_odd),
      .entry_ps         (entry_ps),
      .fixed_ps         (fixed_ps),
      .from_var_section (from_var_section),
      .vaddr            (vaddr),
      .wide_mode        (wide_mode),
      .ps_eff           (ps_eff),
      .desc_sel         (desc_sel),
      .flags            (flags)
   );

   tlbchk_fault u_fault (
      .flags   (flags),
      .access  (access),
      .cur_plv (cur_plv),
      .code    (code)
   );

   tlbchk_paddr #(
      .ENT_W(ENT_W), .VA_W(VA_W), .PA_W(PA_W), .PS_W(PS_W)
   ) u_pa (
      .desc_sel (desc_sel),
      .ps_eff   (ps_eff),
      .vaddr    (vaddr),
      .paddr    (pa_calc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         result    <= 3'd0;
         paddr     <= '0;
         perm_rd   <= 1'b0;
         perm_wr   <= 1'b0;
         perm_ex   <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            result <= code;
            if (code == RC_HIT) begin
               paddr   <= pa_calc;
               perm_rd <= 1'b1;
               perm_wr <= flags.dirty;
               perm_ex <= ~flags.noexec;
            end else begin
               paddr   <= '0;
               perm_rd <= 1'b0;
               perm_wr <= 1'b0;
               perm_ex <= 1'b0;
            end
         end
      end
   end

   // Page size must lie inside the virtual address (R1)
   p_ps_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (ps_eff >= PS_W'(MIN_PS)) && (ps_eff < PS_W'(VA_W)));

   p_rsp_timing_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_rsp_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> $stable(result) && $stable(paddr) && $stable(perm_wr));

   p_exec_fault_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && result == RC_NOEXEC) |-> ($past(access) == AC_FETCH));

   p_clean_fault_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && result == RC_CLEAN) |-> ($past(access) == AC_STORE));

   p_narrow_no_inhibit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !$past(wide_mode)) |-> (result != RC_NOEXEC && result != RC_NOREAD));

   p_hit_readable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && result == RC_HIT) |-> perm_rd);

   p_fault_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && result != RC_HIT) |-> (!perm_rd && !perm_wr && !perm_ex && paddr == '0));
endmodule

// File: tb/sim_tlb_perm_check.sv
`timescale 1ns/1ps
module sim_tlb_perm_check;
   localparam int ENT_W = 64;
   localparam int VA_W  = 48;
   localparam int PA_W  = 48;
   localparam int PS_W  = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic [ENT_W-1:0] desc_even = '0;
   logic [ENT_W-1:0] desc_odd = '0;
   logic [PS_W-1:0]  entry_ps = 6'd12;
   logic [PS_W-1:0]  fixed_ps = 6'd12;
   logic             from_var_section = 1'b0;
   logic [VA_W-1:0]  vaddr = '0;
   logic [1:0]       access = 2'd0;
   logic [1:0]       cur_plv = 2'd0;
   logic             wide_mode = 1'b0;
   logic             rsp_valid;
   logic [2:0]       result;
   logic [PA_W-1:0]  paddr;
   logic             perm_rd, perm_wr, perm_ex;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   tlb_perm_check u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .desc_even(desc_even), .desc_odd(desc_odd),
      .entry_ps(entry_ps), .fixed_ps(fixed_ps),
      .from_var_section(from_var_section), .vaddr(vaddr),
      .access(access), .cur_plv(cur_plv), .wide_mode(wide_mode),
      .rsp_valid(rsp_valid), .result(result), .paddr(paddr),
      .perm_rd(perm_rd), .perm_wr(perm_wr), .perm_ex(perm_ex)
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // Reference model built from R3, R4, R5 using the R9 bit layout
   function automatic logic [2:0] model_code(input logic [6:0] fl, input int acc,
                                             input int cur, input bit wide);
      bit v, d, rp, nr, nx;
      int lvl;
      v = fl[0]; d = fl[1]; lvl = int'(fl[3:2]);
      rp = wide & fl[4]; nr = wide & fl[5]; nx = wide & fl[6];
      if (!v) return 3'd1;
      if (acc == 2 && nx) return 3'd2;
      if (acc == 0 && nr) return 3'd3;
      if (rp ? (cur != lvl) : (cur > lvl)) return 3'd4;
      if (acc == 1 && !d) return 3'd5;
      return 3'd0;
   endfunction

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      int ps_list [4];
      logic [63:0] frame_a, frame_b, va, exp_pa, low_mask;
      logic [2:0] exp_code;
      logic [2:0] held_code;
      logic [PA_W-1:0] held_pa;
      string tag;
      ps_list[0] = 12; ps_list[1] = 13; ps_list[2] = 17; ps_list[3] = 21;

      repeat (2) @(negedge clk);
      // R8: reset state
      chk("R8 reset rsp_valid", 64'(rsp_valid), 64'd0);
      chk("R8 reset result", 64'(result), 64'd0);
      chk("R8 reset paddr", 64'(paddr), 64'd0);
      chk("R8 reset perms", 64'({perm_rd, perm_wr, perm_ex}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int pi = 0; pi < 4; pi++) begin
         for (int sec = 0; sec < 2; sec++) begin
            for (int odd = 0; odd < 2; odd++) begin
               for (int fl = 0; fl < 128; fl++) begin
                  for (int acc = 0; acc < 3; acc++) begin
                     for (int cur = 0; cur < 4; cur++) begin
                        for (int w = 0; w < 2; w++) begin
                           int ps, alt;
                           ps  = ps_list[pi];
                           alt = (ps == 21) ? 12 : 21;
                           // R1: the unused size source carries a different size
                           from_var_section = sec[0];
                           entry_ps = sec ? 6'(ps) : 6'(alt);
                           fixed_ps = sec ? 6'(alt) : 6'(ps);
                           frame_a = 64'h0000_9876_5432_1000 ^ (64'(fl) << 20) ^ 64'hA5A5_0000_0000_0000;
                           frame_b = 64'h0000_3C3C_0F0F_5000;
                           va = 64'h0000_1234_5678_9ABC ^ (64'(cur * 7 + acc) << 3);
                           va[ps] = odd[0];
                           va[alt] = ~odd[0];
                           vaddr = va[VA_W-1:0];
                           // R2: the other half holds the flipped valid bit and another frame
                           if (odd) begin
                              desc_odd  = frame_a | 64'(fl);
                              desc_even = frame_b | 64'(fl ^ 1);
                           end else begin
                              desc_even = frame_a | 64'(fl);
                              desc_odd  = frame_b | 64'(fl ^ 1);
                           end
                           access = 2'(acc);
                           cur_plv = 2'(cur);
                           wide_mode = w[0];
                           req_valid = 1'b1;
                           @(negedge clk);
                           exp_code = model_code(7'(fl), acc, cur, w[0]);
                           low_mask = (64'd1 << ps) - 64'd1;
                           exp_pa = ((frame_a & 64'h0000_FFFF_FFFF_FFFF) & ~low_mask) | (va & low_mask);
                           if (!w[0] && exp_code == 3'd0) tag = "R5 R2 R1 result";
                           else if (exp_code == 3'd4) tag = "R4 R2 R1 result";
                           else tag = "R3 R2 R1 result";
                           chk(tag, 64'(result), 64'(exp_code));
                           chk("R8 rsp_valid", 64'(rsp_valid), 64'd1);
                           if (exp_code == 3'd0) begin
                              chk("R6 paddr", 64'(paddr), exp_pa);
                              chk("R7 perms", 64'({perm_rd, perm_wr, perm_ex}),
                                  64'({1'b1, fl[1], ~(w[0] & fl[6])}));
                           end else begin
                              chk("R7 fault quiet", 64'({paddr, perm_rd, perm_wr, perm_ex}), 64'd0);
                           end
                        end
                     end
                  end
               end
            end
         end
      end

      // R8: no request means outputs hold and no response strobe
      held_code = result;
      held_pa = paddr;
      req_valid = 1'b0;
      desc_even = '0;
      desc_odd = '0;
      @(negedge clk);
      chk("R8 idle rsp_valid", 64'(rsp_valid), 64'd0);
      chk("R8 hold result", 64'(result), 64'(held_code));
      chk("R8 hold paddr", 64'(paddr), 64'(held_pa));

      // R9: bits between the flags and the frame are ignored
      desc_even = 64'h0000_0000_0000_0F83;
      from_var_section = 1'b1; entry_ps = 6'd12; fixed_ps = 6'd12;
      vaddr = 48'h0000_0000_0ABC; access = 2'd1; cur_plv = 2'd0; wide_mode = 1'b1;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 result", 64'(result), 64'd0);
      chk("R9 paddr", 64'(paddr), 64'h0ABC);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule